// File: doc/BRIEF.md
# Parity-Preserving Reversible Full Adder

This block is a one-bit full adder made only of three-line conservative gates. Each gate's output count equals its input count, and its input XOR equals its output XOR. Three gates are fan-out/XOR gates and one is a selecting gate. The adder takes two operand bits, a carry-in and two constant-zero ancilla lines. It returns the sum, the carry and three garbage lines, so five lines go in and five come out.

Every gate has a combinational parity monitor. The monitor compares the XOR of the gate's three input lines with the XOR of its three output lines. A mismatch raises that gate's error flag, and the block error is the OR of all gate flags. A fault-injection vector can invert any gate output line, so a test can prove that the monitors catch a single-line upset at the gate where it happens.

Top module: `rev_full_adder`

## Requirements
- R1: `sum_o` equals `a_i ^ b_i ^ cin_i` for all eight operand patterns when the ancillas are 0 and no fault is injected.
- R2: `cout_o` equals `(a_i & b_i) ^ (a_i & cin_i) ^ (b_i & cin_i)` under the same conditions.
- R3: The garbage lines are `garbage_o[0] = b_i ^ cin_i`, `garbage_o[1] = a_i ^ cin_i` and `garbage_o[2] = (a_i & ~p) ^ (~cin_i & p)` with `p = a_i ^ b_i`. That is exactly three lines.
- R4: With no fault injected, the XOR of the five outputs (sum, carry, three garbage) equals the XOR of the five inputs (a, b, cin, both ancillas).
- R5: With `fault_i` all zero, `gate_err_o` and `err_o` are 0 for every input pattern.
- R6: Gate g uses bits `fault_i[3g+2:3g]`, one bit per output line. The gate order is g0 (operand split), g1 (propagate copy), g2 (sum), g3 (carry select). Inverting exactly one output line of gate g sets `gate_err_o[g]` and `err_o`.
- R7: An upset at one gate output sets only that gate's flag. Downstream gates see a consistent input/output parity and stay clear.
- R8: Inverting two output lines of one gate keeps that gate's parity. It raises no flag.
- R9: Both gate kinds are one-to-one over their eight input patterns and preserve parity. The fan-out gate maps (x, y, z) to (x, x^y, x^z). The selecting gate maps (x, y, z) to (x^y, x&~z ^ ~y&z, x&~z ^ y&z).
- R10: Both ancilla inputs must be held at 0. A nonzero ancilla is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 1 | First operand bit |
| b_i | input | 1 | Second operand bit |
| cin_i | input | 1 | Carry-in |
| anc_i | input | 2 | Constant-zero ancilla lines |
| fault_i | input | 12 | Per-gate output inversion mask, three bits per gate |
| sum_o | output | 1 | Sum |
| cout_o | output | 1 | Carry-out |
| garbage_o | output | 3 | Garbage lines kept for reversibility |
| gate_err_o | output | 4 | Per-gate parity mismatch flags |
| err_o | output | 1 | OR of all gate flags |

## Verification
The block has no registers, so every result settles combinationally in the same cycle as its stimulus. The bench drives inputs on the falling clock edge. It samples all outputs two nanoseconds later, well before the next rising edge, so no check depends on the order of processes at an edge. The gate-level bijection checks drive standalone gate instances in the same way: each pattern is applied, then read back after the same settle delay.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam int unsigned LINE_W    = 3;
  localparam int unsigned NUM_GATES = 4;
  localparam int unsigned NUM_ANC   = 2;
  localparam int unsigned NUM_GARB  = 3;
  localparam int unsigned SEL_IDX   = 3;
  localparam int unsigned FAULT_W   = NUM_GATES * LINE_W;

  typedef enum logic {GK_FANOUT, GK_SELECT} gate_kind_e;
  typedef logic [LINE_W-1:0] line_t;

  // (x,y,z) -> (x, x^y, x^z); bit0 is x
  function automatic line_t fanout_map(line_t v);
    return {v[0] ^ v[2], v[0] ^ v[1], v[0]};
  endfunction

  // (x,y,z) -> (x^y, x~z ^ ~yz, x~z ^ yz); line 2 selects y when z else x
  function automatic line_t select_map(line_t v);
    logic x, y, z;
    x = v[0];
    y = v[1];
    z = v[2];
    return {(x & ~z) ^ (y & z), (x & ~z) ^ (~y & z), x ^ y};
  endfunction
endpackage

// File: rtl/gate_par_mon.sv
module gate_par_mon #(
  parameter int unsigned W = rfa_pkg::LINE_W
) (
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] out_i,
  output logic         err_o
);
  assign err_o = (^in_i) ^ (^out_i);
endmodule

// File: rtl/rev_gate.sv
module rev_gate
  import rfa_pkg::*;
#(
  parameter gate_kind_e KIND = GK_FANOUT
) (
  input  line_t in_i,
  input  line_t flip_i,
  output line_t out_o,
  output logic  err_o
);
  line_t raw;

  generate
    if (KIND == GK_FANOUT) begin : g_fan
      assign raw = fanout_map(in_i);
    end else begin : g_sel
      assign raw = select_map(in_i);
    end
  endgenerate

  assign out_o = raw ^ flip_i;

  gate_par_mon #(.W(LINE_W)) u_mon (
    .in_i  (in_i),
    .out_i (out_o),
    .err_o (err_o)
  );
endmodule

// File: rtl/rev_full_adder.sv
module rev_full_adder
  import rfa_pkg::*;
(
  input  logic                  a_i,
  input  logic                  b_i,
  input  logic                  cin_i,
  input  logic [NUM_ANC-1:0]    anc_i,
  input  logic [FAULT_W-1:0]    fault_i,
  output logic                  sum_o,
  output logic                  cout_o,
  output logic [NUM_GARB-1:0]   garbage_o,
  output logic [NUM_GATES-1:0]  gate_err_o,
  output logic                  err_o
);
  line_t g_in  [NUM_GATES];
  line_t g_out [NUM_GATES];

  // g0: (a, b, 0)        -> (a, p, a)
  // g1: (p, a, 0)        -> (p, b, p)
  // g2: (cin, p, b)      -> (cin, sum, cin^b)
  // g3: (a, cin, p) sel  -> (a^cin, garb, carry)
  assign g_in[0] = {anc_i[0], b_i, a_i};
  assign g_in[1] = {anc_i[1], g_out[0][2], g_out[0][1]};
  assign g_in[2] = {g_out[1][1], g_out[1][0], cin_i};
  assign g_in[3] = {g_out[1][2], g_out[2][0], g_out[0][0]};

  generate
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
      localparam gate_kind_e KIND = (g == SEL_IDX) ? GK_SELECT : GK_FANOUT;
      rev_gate #(.KIND(KIND)) u_gate (
        .in_i   (g_in[g]),
        .flip_i (fault_i[g*LINE_W +: LINE_W]),
        .out_o  (g_out[g]),
        .err_o  (gate_err_o[g])
      );
    end
  endgenerate

  assign sum_o        = g_out[2][1];
  assign cout_o       = g_out[3][2];
  assign garbage_o[0] = g_out[2][2];
  assign garbage_o[1] = g_out[3][0];
  assign garbage_o[2] = g_out[3][1];
  assign err_o        = |gate_err_o;
endmodule

// File: rtl/rfa_chk.sv
module rfa_chk
  import rfa_pkg::*;
(
  input logic                 a_i,
  input logic                 b_i,
  input logic                 cin_i,
  input logic [NUM_ANC-1:0]   anc_i,
  input logic [FAULT_W-1:0]   fault_i,
  input logic                 sum_o,
  input logic                 cout_o,
  input logic [NUM_GARB-1:0]  garbage_o,
  input logic [NUM_GATES-1:0] gate_err_o,
  input logic                 err_o
);
  logic clean;
  assign clean = (fault_i == '0) && (anc_i == '0);

  always_comb begin
    // R10
    anc_zero_chk: assert (anc_i == '0) else $error("ancilla driven nonzero");
    // R1
    sum_ok_chk: assert (!clean || sum_o == (a_i ^ b_i ^ cin_i)) else $error("sum wrong");
    // R2
    carry_ok_chk: assert (!clean || cout_o == ((a_i & b_i) | (a_i & cin_i) | (b_i & cin_i)))
      else $error("carry wrong");
    // R4
    line_parity_chk: assert (fault_i != '0 ||
      (^{sum_o, cout_o, garbage_o}) == (^{a_i, b_i, cin_i, anc_i})) else $error("parity lost");
    // R5
    quiet_err_chk: assert (fault_i != '0 || (gate_err_o == '0 && !err_o))
      else $error("flag without fault");
    // R6
    flag_any_chk: assert (!err_o == (gate_err_o == '0)) else $error("summary flag mismatch");
  end

  generate
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_flag
      always_comb begin
        // R6
        single_flip_chk: assert (!($countones(fault_i[g*LINE_W +: LINE_W]) == 1) || gate_err_o[g])
          else $error("single flip missed");
      end
    end
  endgenerate
endmodule

bind rev_full_adder rfa_chk u_chk (.*);

// File: tb/tb_rev_full_adder.sv
module tb_rev_full_adder;
  import rfa_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic a, b, cin;
  logic [NUM_ANC-1:0]   anc;
  logic [FAULT_W-1:0]   fault;
  logic sum, cout, err;
  logic [NUM_GARB-1:0]  garb;
  logic [NUM_GATES-1:0] gerr;

  rev_full_adder dut (
    .a_i(a), .b_i(b), .cin_i(cin), .anc_i(anc), .fault_i(fault),
    .sum_o(sum), .cout_o(cout), .garbage_o(garb), .gate_err_o(gerr), .err_o(err)
  );

  line_t fin, fout, sin, sout;
  logic  ferr, serr;
  rev_gate #(.KIND(GK_FANOUT)) u_fan (.in_i(fin), .flip_i(3'b000), .out_o(fout), .err_o(ferr));
  rev_gate #(.KIND(GK_SELECT)) u_sel (.in_i(sin), .flip_i(3'b000), .out_o(sout), .err_o(serr));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_adder(logic x, logic y, logic c);
    logic p;
    p = x ^ y;
    // {garb2, garb1, garb0, cout, sum}
    return {(x & ~p) ^ (~c & p), x ^ c, y ^ c, (x & y) | (x & c) | (y & c), x ^ y ^ c};
  endfunction

  function automatic line_t exp_fan(line_t v);
    return {v[0] ^ v[2], v[0] ^ v[1], v[0]};
  endfunction

  function automatic line_t exp_sel(line_t v);
    return {v[2] ? v[1] : v[0], v[2] ? ~v[1] : v[0], v[0] ^ v[1]};
  endfunction

  task automatic apply(input logic [2:0] v, input logic [FAULT_W-1:0] f);
    @(negedge clk);
    {cin, b, a} = v;
    fault = f;
    #2;
  endtask

  initial begin
    a = 0; b = 0; cin = 0; anc = '0; fault = '0; fin = '0; sin = '0;
    void'($urandom(32'd1207));
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #2;
    chk(err == 0 && gerr == 0, "R5 reset idle", {gerr, err}, 0);

    for (int v = 0; v < 8; v++) begin
      logic [4:0] e;
      apply(v[2:0], '0);
      e = exp_adder(v[0], v[1], v[2]);
      chk(sum == e[0], "R1 sum", sum, e[0]);
      chk(cout == e[1], "R2 carry", cout, e[1]);
      chk(garb == e[4:2], "R3 garbage", garb, e[4:2]);
      chk((^{sum, cout, garb}) == (^v[2:0]), "R4 line parity", ^{sum, cout, garb}, ^v[2:0]);
      chk(err == 0 && gerr == 0, "R5 no fault quiet", {gerr, err}, 0);
    end

    // directed: every single line of every gate
    for (int g = 0; g < NUM_GATES; g++) begin
      for (int k = 0; k < LINE_W; k++) begin
        logic [FAULT_W-1:0] f;
        f = '0;
        f[g*LINE_W + k] = 1'b1;
        apply(3'($urandom_range(0, 7)), f);
        chk(err == 1, "R6 single flip flagged", err, 1);
        chk(gerr == (4'b1 << g), "R7 only faulted gate", gerr, 4'b1 << g);
      end
    end

    // random single and double flips
    for (int n = 0; n < 40; n++) begin
      logic [FAULT_W-1:0] f;
      int g, k, k2;
      g = $urandom_range(0, NUM_GATES - 1);
      k = $urandom_range(0, LINE_W - 1);
      f = '0;
      f[g*LINE_W + k] = 1'b1;
      if (n % 2 == 1) begin
        k2 = (k + 1 + $urandom_range(0, 1)) % LINE_W;
        f[g*LINE_W + k2] = 1'b1;
        apply(3'($urandom_range(0, 7)), f);
        chk(err == 0 && gerr == 0, "R8 double flip unseen", {gerr, err}, 0);
      end else begin
        apply(3'($urandom_range(0, 7)), f);
        chk(err == 1 && gerr == (4'b1 << g), "R6 R7 random flip", {gerr, err}, {4'b1 << g, 1'b1});
      end
    end

    // gate models: one-to-one and parity preserving
    begin
      bit [7:0] fseen, sseen;
      fseen = '0; sseen = '0;
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        fin = v[2:0];
        sin = v[2:0];
        #2;
        chk(fout == exp_fan(v[2:0]), "R9 fanout map", fout, exp_fan(v[2:0]));
        chk(sout == exp_sel(v[2:0]), "R9 select map", sout, exp_sel(v[2:0]));
        chk(!fseen[fout] && !sseen[sout], "R9 distinct outputs", {fseen[fout], sseen[sout]}, 0);
        chk(!ferr && !serr && (^fout) == (^v[2:0]) && (^sout) == (^v[2:0]),
            "R9 parity kept", {ferr, serr}, 0);
        fseen[fout] = 1'b1;
        sseen[sout] = 1'b1;
      end
      chk(fseen == 8'hff && sseen == 8'hff, "R9 full coverage", {fseen, sseen}, 16'hffff);
    end

    apply(3'b000, '0);
    chk(anc == '0 && err == 0, "R10 ancillas held low", {anc, err}, 0);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule